// File: doc/BRIEF.md
# Dual-Path Held-Data Bus Transceiver

This block joins two 8-bit buses, called side A and side B, through two independent storage paths. The forward path carries side-A data to side B. The return path carries side-B data to side A. Each path has its own storage register and three active-low controls: a path select, a hold request and a drive request. A path stores whatever its source side presents while it is selected and not holding. It keeps that value once it is told to hold, or once it is deselected. Its destination side is driven only while the path is both selected and asked to drive.

The buses are modelled without true inout pins. Each side has a data input, a data output and an output-enable. An output-enable at 0 stands for high impedance. The storage is clocked rather than level-sensitive. The controls and the source data are sampled on the rising edge of `clk`, so a value that enters the store appears on the destination output one cycle later. The drive enables are decoded combinationally from the present controls. A flag reports when both sides are driven at once.

Top module: `xcvr_bidir_latched`

## Requirements
- R1: While `rst_n` is 0, `a_oe` and `b_oe` are 0 in the same cycle. A rising clock edge with `rst_n` at 0 clears both stores to zero, so `a_out` and `b_out` read 0 after that edge.
- R2: At a rising edge where `fwd_sel_n` and `fwd_hold_n` are both 0, the forward store takes `a_in`. The new value is visible on `b_out` after that edge.
- R3: At a rising edge where `fwd_sel_n` is 1, the forward store keeps its value, whatever `fwd_hold_n`, `fwd_drive_n` and `a_in` are. While `fwd_sel_n` is 1, `b_oe` is 0.
- R4: At a rising edge where `fwd_sel_n` is 0 and `fwd_hold_n` is 1, the forward store keeps its value.
- R5: `b_oe` is 1 exactly when `rst_n` is 1 and both `fwd_sel_n` and `fwd_drive_n` are 0. It follows the controls within the same cycle.
- R6: `b_out` shows the forward store even while `b_oe` is 0. A value held through a period with the drive off reappears unchanged once the drive is switched back on.
- R7: The return path behaves the same way with `ret_sel_n`, `ret_hold_n` and `ret_drive_n`. It stores `b_in`, shows the value on `a_out`, and drives `a_oe`.
- R8: The controls and data of one path never change the store of the other path.
- R9: `contention` is 1 exactly when `a_oe` and `b_oe` are both 1. Each side's enable still follows its own path.
- R10: After the hold request rises while the path is selected, later changes on the source input leave the destination output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for both stores |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 8 | Data seen on side A |
| a_out | output | 8 | Return-path store, presented to side A |
| a_oe | output | 1 | Side A drive enable (0 = high impedance) |
| b_in | input | 8 | Data seen on side B |
| b_out | output | 8 | Forward-path store, presented to side B |
| b_oe | output | 1 | Side B drive enable (0 = high impedance) |
| fwd_sel_n | input | 1 | Forward path select, active low |
| fwd_hold_n | input | 1 | Forward path load when low, hold when high |
| fwd_drive_n | input | 1 | Forward path drive request, active low |
| ret_sel_n | input | 1 | Return path select, active low |
| ret_hold_n | input | 1 | Return path load when low, hold when high |
| ret_drive_n | input | 1 | Return path drive request, active low |
| contention | output | 1 | Both sides driven at once |

## Verification
A store that loads when it should hold, or holds when it should load, shows up one clock edge later on the destination data output. That output is visible whatever the drive state is, so the fault cannot hide behind a disabled side. A wrong enable decode appears on `a_oe`, `b_oe` or `contention` in the same cycle that the controls change. The sweep covers every combination of the six control bits, so a fault in any row of either path's control table shows up within one cycle of that row being applied.

// File: rtl/xcvr_pkg.sv
// Shared types for the held-data bus transceiver.
// Assumes: each path is controlled by one select, one hold and one drive bit, all active low.
package xcvr_pkg;

    // The three active-low controls of one storage path.
    typedef struct packed {
        logic sel_n;
        logic hold_n;
        logic drive_n;
    } xcvr_ctl_t;

    // What a path's store does at the next rising edge.
    typedef enum logic [1:0] {
        STORE_CLEAR = 2'd0,
        STORE_OFF   = 2'd1,
        STORE_HOLD  = 2'd2,
        STORE_LOAD  = 2'd3
    } store_mode_e;

    localparam int unsigned NUM_PATHS = 2;
    localparam int unsigned PATH_FWD  = 0;
    localparam int unsigned PATH_RET  = 1;

endpackage

// File: rtl/xcvr_ctl_decode.sv
// Control decoder for one storage path.
// Turns the three active-low controls and the reset into a store action and a drive enable.
// Assumes: reset takes priority over every other control; deselection wins over hold and load.
module xcvr_ctl_decode
    import xcvr_pkg::*;
(
    input  logic        rst_n,
    input  xcvr_ctl_t   ctl,
    output store_mode_e mode,
    output logic        drv_en
);

    // Pick the store action for the next edge.
    always_comb begin
        if (!rst_n) begin
            mode = STORE_CLEAR;
        end else if (ctl.sel_n) begin
            mode = STORE_OFF;
        end else if (ctl.hold_n) begin
            mode = STORE_HOLD;
        end else begin
            mode = STORE_LOAD;
        end
    end

    // Drive the destination side only when selected, asked to drive and out of reset.
    always_comb begin
        drv_en = rst_n && !ctl.sel_n && !ctl.drive_n;
    end

endmodule

// File: rtl/xcvr_store.sv
// Data store for one path, parameterised in width.
// Loads, clears or keeps its contents on each rising edge, as the decoded mode says.
// Assumes: the clear action carries the synchronous reset.
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  store_mode_e      mode,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Update the stored word on each rising edge.
    always_ff @(posedge clk) begin
        case (mode)
            STORE_CLEAR: q <= '0;
            STORE_LOAD:  q <= d;
            default:     q <= q;
        endcase
    end

endmodule

// File: rtl/xcvr_path.sv
// One direction of the transceiver: a control decoder plus a data store.
// The output word always shows the store. The drive enable says whether the destination bus is driven.
// Assumes: the controls and the data are synchronous to clk.
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xcvr_ctl_t        ctl,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] q,
    output logic             drv_en
);

    store_mode_e mode;

    xcvr_ctl_decode u_dec (
        .rst_n  (rst_n),
        .ctl    (ctl),
        .mode   (mode),
        .drv_en (drv_en)
    );

    xcvr_store #(.WIDTH(WIDTH)) u_store (
        .clk  (clk),
        .mode (mode),
        .d    (src),
        .q    (q)
    );

    // R3: a deselected path keeps its stored word.
    assert_hold_desel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sel_n |=> $stable(q));

    // R4: a selected path with hold requested keeps its stored word.
    assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.sel_n && ctl.hold_n) |=> $stable(q));

    // R2: a selected, non-holding path takes the source word.
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.sel_n && !ctl.hold_n) |=> (q == $past(src)));

    // R5: the drive enable is never raised without select and drive request.
    assert_drive_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (!ctl.sel_n && !ctl.drive_n));

endmodule

// File: rtl/xcvr_bidir_latched.sv
// Top level of the held-data bus transceiver.
// Two xcvr_path instances: the forward path stores side A and presents to side B; the return path does the reverse.
// Assumes: the bus sides are split into in, out and output-enable; high impedance is oe = 0.
module xcvr_bidir_latched
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             fwd_sel_n,
    input  logic             fwd_hold_n,
    input  logic             fwd_drive_n,
    input  logic             ret_sel_n,
    input  logic             ret_hold_n,
    input  logic             ret_drive_n,
    output logic             contention
);

    xcvr_ctl_t [NUM_PATHS-1:0]             ctl_v;
    logic      [NUM_PATHS-1:0][WIDTH-1:0] src_v;
    logic      [NUM_PATHS-1:0][WIDTH-1:0] q_v;
    logic      [NUM_PATHS-1:0]            drv_v;

    // Route the controls and source words of both directions into indexed arrays.
    always_comb begin
        ctl_v[PATH_FWD] = '{sel_n: fwd_sel_n, hold_n: fwd_hold_n, drive_n: fwd_drive_n};
        ctl_v[PATH_RET] = '{sel_n: ret_sel_n, hold_n: ret_hold_n, drive_n: ret_drive_n};
        src_v[PATH_FWD] = a_in;
        src_v[PATH_RET] = b_in;
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        xcvr_path #(.WIDTH(WIDTH)) u_path (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl    (ctl_v[p]),
            .src    (src_v[p]),
            .q      (q_v[p]),
            .drv_en (drv_v[p])
        );
    end

    // Present each store on its destination side and flag a double drive.
    always_comb begin
        b_out      = q_v[PATH_FWD];
        b_oe       = drv_v[PATH_FWD];
        a_out      = q_v[PATH_RET];
        a_oe       = drv_v[PATH_RET];
        contention = drv_v[PATH_FWD] & drv_v[PATH_RET];
    end

    // R1: neither side is driven during reset.
    always_comb begin
        if (rst_n === 1'b0) begin
            assert_no_drive_in_reset_R1: assert (!a_oe && !b_oe);
        end
    end

endmodule

// File: tb/xcvr_bidir_latched_tb.sv
module xcvr_bidir_latched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, contention;
    logic         fwd_sel_n = 1'b1, fwd_hold_n = 1'b1, fwd_drive_n = 1'b1;
    logic         ret_sel_n = 1'b1, ret_hold_n = 1'b1, ret_drive_n = 1'b1;

    int unsigned  checks = 0;
    int unsigned  errors = 0;
    bit           done = 1'b0;
    logic [W-1:0] exp_fwd = '0, exp_ret = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_bidir_latched #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .fwd_sel_n(fwd_sel_n), .fwd_hold_n(fwd_hold_n), .fwd_drive_n(fwd_drive_n),
        .ret_sel_n(ret_sel_n), .ret_hold_n(ret_hold_n), .ret_drive_n(ret_drive_n),
        .contention(contention)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: controls are {sel_n, hold_n, drive_n}. Enables are checked at once, stores after the edge.
    task automatic step(input logic rst_v, input logic [2:0] fc, input logic [2:0] rc,
                        input logic [W-1:0] av, input logic [W-1:0] bv);
        logic exp_boe, exp_aoe;
        string tf;
        @(negedge clk);
        rst_n = rst_v;
        {fwd_sel_n, fwd_hold_n, fwd_drive_n} = fc;
        {ret_sel_n, ret_hold_n, ret_drive_n} = rc;
        a_in = av;
        b_in = bv;
        #1;
        exp_boe = rst_v && !fc[2] && !fc[0];
        exp_aoe = rst_v && !rc[2] && !rc[0];
        chk(rst_v ? (fc[2] ? "R3" : "R5") : "R1", {7'b0, b_oe}, {7'b0, exp_boe});
        chk(rst_v ? "R7" : "R1", {7'b0, a_oe}, {7'b0, exp_aoe});
        chk("R9", {7'b0, contention}, {7'b0, exp_boe && exp_aoe});
        if (!rst_v) begin
            exp_fwd = '0;
            exp_ret = '0;
            tf = "R1";
        end else begin
            if (!fc[2] && !fc[1]) exp_fwd = av;
            if (!rc[2] && !rc[1]) exp_ret = bv;
            tf = fc[2] ? "R3" : (fc[1] ? "R4" : "R2");
        end
        @(posedge clk);
        #1;
        chk(tf, b_out, exp_fwd);
        chk(rst_v ? "R7" : "R1", a_out, exp_ret);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] keep;
        // R1: reset with every enable low
        step(1'b0, 3'b000, 3'b000, 8'hFF, 8'hEE);
        step(1'b0, 3'b000, 3'b000, 8'h11, 8'h22);
        chk("R1", b_out, 8'h00);

        // Exhaustive sweep over all six control bits, two data sets
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 64; i++) begin
                step(1'b1, i[2:0], i[5:3], W'(i * 37 + p * 101 + 5), W'(i * 91 + p * 53 + 3));
            end
        end

        // R8: loading the forward path leaves the return store alone
        step(1'b1, 3'b001, 3'b000, 8'h10, 8'h77);
        keep = a_out;
        step(1'b1, 3'b000, 3'b100, 8'h20, 8'h99);
        chk("R8", a_out, keep);
        step(1'b1, 3'b100, 3'b001, 8'h30, 8'h44);
        chk("R8", b_out, 8'h20);

        // R10: hold rises, then the source keeps moving
        step(1'b1, 3'b000, 3'b111, 8'h5A, 8'h00);
        step(1'b1, 3'b010, 3'b111, 8'hA5, 8'h00);
        chk("R10", b_out, 8'h5A);
        step(1'b1, 3'b010, 3'b111, 8'h3C, 8'h00);
        chk("R10", b_out, 8'h5A);

        // R6: drive off while held, then back on
        step(1'b1, 3'b111, 3'b111, 8'hC3, 8'h00);
        step(1'b1, 3'b011, 3'b111, 8'h0F, 8'h00);
        chk("R6", b_out, 8'h5A);
        step(1'b1, 3'b010, 3'b111, 8'hF0, 8'h00);
        chk("R6", {7'b0, b_oe}, 8'h01);
        chk("R6", b_out, 8'h5A);

        // R1: reset in mid-run clears both stores
        step(1'b0, 3'b000, 3'b000, 8'h12, 8'h34);
        chk("R1", a_out, 8'h00);
        step(1'b1, 3'b111, 3'b111, 8'h00, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule